// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block lets a microcontroller on a two-wire I2C bus read and write a small file of 8-bit registers. The bus lines are sampled by the system clock, which must run much faster than SCL. The lines pass through synchronizers, and their edges are detected inside the block. The slave answers a 7-bit device address. The top five bits of that address are the constant `10011`. The two low bits are taken from a pair of strap inputs, and these are captured only while reset is held.

A write transaction carries a pointer byte and then optional data bytes. In the pointer byte, bit 7 turns auto-increment on and bits 6:0 name the register. A read returns data from the register picked by the last pointer byte received. The usual read is a pointer-only write, then a repeated start, then the address with R/W = 1. SDA is modelled as an open-drain enable: `sda_oe = 1` pulls the line low.

The controller is a single state machine with these states: `ST_IDLE`, `ST_ADDR` (address shift-in), `ST_ADDR_ACK`, `ST_PTR` (pointer shift-in), `ST_PTR_ACK`, `ST_WDAT` (data shift-in), `ST_WDAT_ACK`, `ST_RDAT` (byte shift-out), `ST_RACK` (master acknowledge) and `ST_IGNORE`. The transitions are:
- A start in any state goes to `ST_ADDR`, and a stop in any state goes to `ST_IDLE`.
- From `ST_ADDR`, the eighth bit goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_RDAT` for a read and to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_PTR_ACK`, which goes to `ST_WDAT`.
- `ST_WDAT` and `ST_WDAT_ACK` alternate, one pass per data byte.
- `ST_RDAT` goes to `ST_RACK` after eight bits. `ST_RACK` goes back to `ST_RDAT` on an ACK and to `ST_IGNORE` on a NACK.

Top module: `i2cs_port`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe` is 0, every register reads 0x00, and neither strobe pulses.
- R2: SDA falling while SCL is high is a start, and it restarts address reception from any state, including part way through a byte. SDA rising while SCL is high is a stop, and it returns the slave to idle. The pointer survives both.
- R3: The slave answers only the address `10011` followed by the strap pair (strap bit 1 above bit 0) as latched during reset; strap changes after reset have no effect. Any other address is not acknowledged, and SDA stays released until the next start or stop.
- R4: After a matching address byte, a pointer byte and every data byte written, the slave holds SDA low for the whole ninth SCL clock. It changes `sda_oe` only while SCL is low.
- R5: The first byte after a write address is the pointer. Bit 7 enables auto-increment and bits 6:0 are the register index.
- R6: Each data byte written to an existing index is stored in that register and gives `wr_stb` high for exactly one clock, with `wr_idx` and `wr_data`.
- R7: With auto-increment on, successive bytes of one transaction use consecutive indices. With it off, every byte uses the same index.
- R8: A read shifts out the selected register MSB first. At each byte load, `rd_stb` pulses for one clock with `rd_idx`.
- R9: A master NACK after a read byte ends the read: SDA stays released until the next start or stop.
- R10: There are 16 registers. Incrementing a pointer at or above 15 gives 0. A write to an index of 16 or more is acknowledged but discarded with no strobe, and a read from such an index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset; straps latched while low |
| addr_strap | input | 2 | Low two device-address bits (bit 1 above bit 0) |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_stb | output | 1 | One-clock pulse per committed register write |
| wr_idx | output | 7 | Register index of the committed write |
| wr_data | output | 8 | Data of the committed write |
| rd_stb | output | 1 | One-clock pulse when a read byte is loaded |
| rd_idx | output | 7 | Register index of the loaded read byte |

## Verification
Some faults in the state machine are internal: a bit counter that is off by one, a pointer that increments at the wrong time, or a latched strap value that is lost. These faults reach the bus within the same byte. They show up either as a missing or misplaced acknowledge on the ninth clock, or as the wrong strobe index appearing when the byte ends. A fault in the stored data or in the wrap logic stays hidden until a later read. For that reason, the random traffic mixes pointer-only writes, repeated-start reads and out-of-range pointers, so that every stored value is read back through the bus within a few transactions.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_IGNORE
    } sl_state_t;

    localparam logic [4:0] DEV_PREFIX = 5'b10011;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
    parameter int NREG = 16,
    parameter int IW   = 7,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && widx == IW'(g))
                mem[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (ridx == IW'(i)) rdata = mem[i];
    end
endmodule

// File: rtl/i2cs_port.sv
module i2cs_port
    import i2cs_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_strap,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [6:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       rd_stb,
    output logic [6:0] rd_idx
);
    localparam int IW = 7;
    localparam int DW = 8;
    localparam logic [IW-1:0] LAST_IDX = IW'(NREG - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [1:0]    strap_q;
    sl_state_t     state, state_d;
    logic [3:0]    cnt;
    logic [DW-1:0] sh, tx, rdata;
    logic [IW-1:0] ptr;
    logic          inc, rw, nack;
    logic          byte_done, addr_hit, commit, load_rd;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p >= LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_regs #(.NREG(NREG), .IW(IW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(commit), .widx(ptr), .wdata(sh),
        .ridx(ptr), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= addr_strap;
    end

    assign byte_done = scl_fall && cnt == 4'd8;
    assign addr_hit  = sh[7:1] == {DEV_PREFIX, strap_q};
    assign commit    = state == ST_WDAT && byte_done && ptr <= LAST_IDX;
    assign load_rd   = !start_det && !stop_det && scl_fall &&
                       ((state == ST_ADDR_ACK && rw) || (state == ST_RACK && !nack));

    // next-state logic
    always_comb begin
        state_d = state;
        if (stop_det)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_ADDR;
        else begin
            unique case (state)
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = rw ? ST_RDAT : ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall)  state_d = ST_WDAT;
                ST_WDAT:     if (byte_done) state_d = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall)  state_d = ST_WDAT;
                ST_RDAT:     if (scl_fall && cnt == 4'd7) state_d = ST_RACK;
                ST_RACK:     if (scl_fall)  state_d = nack ? ST_IGNORE : ST_RDAT;
                default:     state_d = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath: shifters, counter, pointer, strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sh <= '0; tx <= '1; ptr <= '0;
            inc <= 1'b0; rw <= 1'b0; nack <= 1'b0;
            wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0;
            rd_stb <= 1'b0; rd_idx <= '0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (start_det || stop_det) begin
                cnt <= '0;
            end else begin
                if ((state == ST_ADDR || state == ST_PTR || state == ST_WDAT)) begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                    end
                end
                if (state == ST_ADDR && byte_done) rw <= sh[0];
                if (state == ST_PTR && byte_done) begin
                    ptr <= sh[6:0];
                    inc <= sh[7];
                end
                if (state == ST_WDAT && byte_done) begin
                    wr_stb  <= commit;
                    wr_idx  <= ptr;
                    wr_data <= sh;
                    if (inc) ptr <= nxt(ptr);
                end
                if (state == ST_RDAT && scl_fall) begin
                    tx  <= {tx[6:0], 1'b1};
                    cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 1'b1;
                end
                if (state == ST_RACK && scl_rise) nack <= sda_s;
                if (load_rd) begin
                    tx     <= rdata;
                    rd_stb <= 1'b1;
                    rd_idx <= ptr;
                    cnt    <= '0;
                    if (inc) ptr <= nxt(ptr);
                end
            end
        end
    end

    // output logic: open-drain enable
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:                              sda_oe = ~tx[7];
            default:                              sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2cs_port_chk.sv
module i2cs_port_chk #(
    parameter int NREG = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [6:0] wr_idx,
    input logic       rd_stb,
    input logic [1:0] strap_q
);
    AST_RESET_RELEASED: assert property (@(posedge clk) !rst_n |-> !sda_oe && !wr_stb && !rd_stb); // R1
    AST_OE_SCL_LOW:     assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_in); // R4
    AST_WR_PULSE:       assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R6
    AST_RD_PULSE:       assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb); // R8
    AST_WR_IN_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> 32'(wr_idx) < NREG); // R10
    AST_STRAP_HELD:     assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> $stable(strap_q)); // R3
endmodule

bind i2cs_port i2cs_port_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .rd_stb(rd_stb), .strap_q(strap_q)
);

// File: tb/sim_i2cs_port.sv
`timescale 1ns/1ps
module sim_i2cs_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr_strap = 2'b10;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, wr_stb, rd_stb;
    logic [6:0] wr_idx, rd_idx;
    logic [7:0] wr_data;
    wire sda_line = sda_m & ~sda_oe;

    localparam logic [7:0] DEV_W = 8'h9C;
    localparam logic [7:0] DEV_R = 8'h9D;

    int checks = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [6:0] last_wi, last_ri;
    logic [7:0] last_wd;
    logic [7:0] m_regs [16];
    logic [6:0] m_ptr = '0;
    logic m_inc = 1'b0;

    always #4 clk = ~clk;

    i2cs_port u0 (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .scl_in(scl_m),
        .sda_in(sda_line), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_idx(rd_idx)
    );

    always @(negedge clk) begin
        if (wr_stb) begin wr_cnt++; last_wi = wr_idx; last_wd = wr_data; end
        if (rd_stb) begin rd_cnt++; last_ri = rd_idx; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] nxt(input logic [6:0] p);
        return (p >= 7'd15) ? 7'd0 : p + 7'd1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [6:0] p);
        return (p < 7'd16) ? m_regs[p[3:0]] : 8'h00;
    endfunction

    task automatic wq(input int n);
        repeat (n * 5) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(1); scl_m = 1; wq(2); sda_m = 0; wq(2); scl_m = 0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(1); scl_m = 1; wq(2); sda_m = 1; wq(2);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1; wq(1); scl_m = 1; wq(1); b = sda_line; wq(1); scl_m = 0; wq(1);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
        put_bit(!mack);
    endtask

    task automatic wr_data_byte(input logic [7:0] d, input string req);
        logic ack;
        int c0 = wr_cnt;
        send_byte(d, ack);
        chk({req, " data ack R4"}, ack, 1);
        if (m_ptr < 7'd16) begin
            chk({req, " strobe count R6"}, wr_cnt, c0 + 1);
            chk({req, " strobe idx R6"}, last_wi, m_ptr);
            chk({req, " strobe data R6"}, last_wd, d);
            m_regs[m_ptr[3:0]] = d;
        end else begin
            chk({req, " discarded R10"}, wr_cnt, c0);
        end
        if (m_inc) m_ptr = nxt(m_ptr);
    endtask

    task automatic set_ptr(input logic [7:0] pb, input string req);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack); chk({req, " addr ack R3"}, ack, 1);
        send_byte(pb, ack);    chk({req, " ptr ack R5"}, ack, 1);
        m_ptr = pb[6:0]; m_inc = pb[7];
    endtask

    task automatic read_n(input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_R, ack); chk({req, " read addr ack R8"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            chk({req, " read data R8"}, d, exp_rd(m_ptr));
            if (m_inc) m_ptr = nxt(m_ptr);
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        int seed;
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        seed = 1234;
        void'($urandom(seed));
        repeat (5) @(negedge clk);
        chk("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1;
        @(negedge clk);
        addr_strap = 2'b01;          // R3: later strap change must not matter
        wq(2);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 no strobes", wr_cnt + rd_cnt, 0);

        set_ptr(8'h80, "R1 pre"); read_n(3, "R1 reset values");

        // R3: address with new strap value, wrong prefix
        bus_start(); send_byte(8'h9A, ack); chk("R3 new strap nack", ack, 0);
        send_byte(8'h55, ack); chk("R3 ignored byte nack", ack, 0);
        chk("R3 no strobe while ignored", wr_cnt, 0);
        bus_stop();
        bus_start(); send_byte(8'hA0, ack); chk("R3 wrong prefix nack", ack, 0); bus_stop();

        // R5/R6/R7 auto-increment burst, then read back
        set_ptr(8'h85, "R7 inc");
        wr_data_byte(8'hA1, "R7"); wr_data_byte(8'hB2, "R7"); wr_data_byte(8'hC3, "R7");
        bus_stop();
        set_ptr(8'h85, "R8 rb"); read_n(3, "R8 burst");
        chk("R8 last rd_idx", last_ri, 7);

        // R7 fixed pointer
        set_ptr(8'h03, "R7 fixed");
        wr_data_byte(8'h11, "R7 fixed"); wr_data_byte(8'h22, "R7 fixed");
        bus_stop();
        set_ptr(8'h03, "R7 fixed rb"); read_n(2, "R7 fixed");

        // R10 wrap and out-of-range
        set_ptr(8'h8F, "R10 wrap");
        wr_data_byte(8'h5A, "R10 wrap"); wr_data_byte(8'h6B, "R10 wrap");
        chk("R10 wrapped ptr", last_wi, 0);
        bus_stop();
        set_ptr(8'h94, "R10 oor"); wr_data_byte(8'h77, "R10 oor"); bus_stop();
        set_ptr(8'h14, "R10 oor rd"); read_n(1, "R10 oor read");

        // R9 NACK ends read
        set_ptr(8'h85, "R9");
        bus_start(); send_byte(DEV_R, ack); chk("R9 addr ack", ack, 1);
        recv_byte(d, 1'b0); chk("R9 first byte", d, 8'hA1);
        recv_byte(d, 1'b0); chk("R9 released after nack", d, 8'hFF);
        bus_stop();
        m_ptr = 7'd6;

        // R2 start mid-byte, stop mid-transaction keeps pointer
        bus_start(); put_bit(1); put_bit(0); put_bit(0); put_bit(1);
        bus_start(); send_byte(DEV_W, ack); chk("R2 restart addr ack", ack, 1);
        send_byte(8'h0A, ack); chk("R2 ptr ack", ack, 1);
        m_ptr = 7'd10; m_inc = 1'b0;
        wr_data_byte(8'h5C, "R2 after restart");
        bus_stop();
        set_ptr(8'h02, "R2 stop"); bus_stop();
        read_n(1, "R2 pointer kept");

        // random traffic
        for (int t = 0; t < 40; t++) begin
            int n = $urandom_range(1, 3);
            logic [7:0] pb = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 19))};
            set_ptr(pb, "R6 rand");
            if ($urandom_range(0, 1) == 1) begin
                for (int k = 0; k < n; k++) wr_data_byte(8'($urandom_range(0, 255)), "R6 rand");
                bus_stop();
            end else begin
                read_n(n, "R8 rand");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule